// File: doc/BRIEF.md
# Receive Status Flags and Interrupt Generator

This block sits beside the receive datapath of a multichannel time-division-multiplexed audio serial receiver. It turns single-cycle event pulses into sticky status flags that software reads and then clears by writing ones. The events are:

- new word transferred
- final slot of a frame
- frame sync edge
- clock failure
- sync error
- overrun
- extra data-port reads

The block also provides a per-slot read counter. This counter detects a data port that is read more times in one slot than there are active receive serializers.

The status word holds two read-only fields. One is an aggregated error bit that lets one test cover every error source. The other shows whether the current slot is even or odd. An enable register selects which flags drive the level-type receive interrupt. Every data transfer raises a one-cycle DMA request, whatever the enables are. Software reaches both registers through a simple single-cycle write port and a combinational read port, selected by one address bit.

Top module: `rx_status_reg`

## Requirements
- R1: Each event pulse sets its sticky flag on the next clock edge, at these status bit positions: overrun bit 0, sync error bit 1, clock failure bit 2, data ready bit 5, start of frame bit 6, excess reads bit 7.
- R2: A write to the status register (reg_addr 0) clears each flag whose wdata bit is 1; a 0 bit leaves the flag as it is.
- R3: When a set event and a write-1 clear reach the same flag in the same cycle, the flag stays set.
- R4: Status bit 8 always reads as the OR of flag bits 0, 1, 2 and 7.
- R5: The last-slot flag (bit 4) is set only when evt_last_slot and evt_data are high in the same cycle; evt_last_slot alone changes nothing.
- R6: Status bit 3 reads 1 when slot_num is even and 0 when it is odd.
- R7: slot_start clears the per-slot read counter, and a read in that same cycle counts as the first read of the new slot. A port_rd that makes the count of reads in the slot exceed rx_count sets flag bit 7.
- R8: The enable register (reg_addr 1) uses the flag bit positions and reads back only bits 7..4 and 2..0. rx_int is high while any flag is set together with its enable bit.
- R9: After a same-cycle set/clear collision on an enabled flag, rx_int is low for exactly one cycle and then rises again.
- R10: dma_req is high for exactly one cycle, one cycle after evt_data, whatever the enables are.
- R11: After reset, all flags and enables are 0. Status bits 31..9 always read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_data | input | 1 | A received word has moved to the read buffer |
| evt_last_slot | input | 1 | The word moved with evt_data was the frame's final slot |
| evt_frame | input | 1 | New receive frame sync edge detected |
| evt_clk_fail | input | 1 | Clock failure detector fired |
| evt_sync_err | input | 1 | Unexpected frame sync |
| evt_overrun | input | 1 | Read buffer overwritten before service |
| slot_num | input | SLOT_W | Current receive slot number |
| slot_start | input | 1 | First cycle of a new slot |
| port_rd | input | 1 | One data-port read |
| rx_count | input | RD_W | Number of serializers programmed as receivers |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| rx_int | output | 1 | Receive interrupt level |
| dma_req | output | 1 | One-cycle receive DMA request |

## Verification
The bench drives each event into a collision with a write-1 clear of its own flag. A design where the clear wins would lose the flag, and a design without the collision gap would hold rx_int flat, so an edge-sensitive controller would never see the new request. The last-slot qualifier is pulsed on its own, which catches a flag wired to it alone. The read counter is run up to and past rx_count, across a slot_start that carries a read, and with rx_count of zero. These runs expose off-by-one limits and a counter that does not clear at the boundary. Writes of zeros and of reserved bits check that only write-1 on a flag bit has any effect.

// File: rtl/rx_status_reg.sv
`timescale 1ns/100ps
module rx_status_reg #(
  parameter int SLOT_W = 5,
  parameter int RD_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_data,
  input  logic              evt_last_slot,
  input  logic              evt_frame,
  input  logic              evt_clk_fail,
  input  logic              evt_sync_err,
  input  logic              evt_overrun,
  input  logic [SLOT_W-1:0] slot_num,
  input  logic              slot_start,
  input  logic              port_rd,
  input  logic [RD_W-1:0]   rx_count,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              rx_int,
  output logic              dma_req
);
  localparam logic [7:0]      FLAG_MASK = 8'hF7;
  localparam logic [RD_W-1:0] CNT_MAX   = '1;

  logic [7:0]      flags, en, set_v, clr_v;
  logic [RD_W-1:0] rd_cnt, rd_eff;
  logic            rd_over, collide, collide_q, err;
  logic            unused_bits;

  assign unused_bits = ^{reg_wdata[31:8], slot_num[SLOT_W-1:1]};

  assign rd_eff  = slot_start ? '0 : rd_cnt;
  assign rd_over = port_rd && (rd_eff >= rx_count);

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_cnt <= '0;
    else if (port_rd && rd_eff != CNT_MAX)
      rd_cnt <= rd_eff + 1'b1;
    else
      rd_cnt <= rd_eff;
  end

  assign set_v = {rd_over, evt_frame, evt_data, evt_data & evt_last_slot,
                  1'b0, evt_clk_fail, evt_sync_err, evt_overrun};
  assign clr_v = (reg_wr && !reg_addr) ? (reg_wdata[7:0] & FLAG_MASK) : 8'h00;
  assign collide = |(set_v & clr_v & en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags     <= 8'h00;
      en        <= 8'h00;
      collide_q <= 1'b0;
      dma_req   <= 1'b0;
    end else begin
      flags     <= (flags & ~clr_v) | set_v;
      if (reg_wr && reg_addr)
        en      <= reg_wdata[7:0] & FLAG_MASK;
      collide_q <= collide;
      dma_req   <= evt_data;
    end
  end

  assign err       = flags[0] | flags[1] | flags[2] | flags[7];
  assign reg_rdata = reg_addr ? {24'h0, en}
                              : {23'h0, err, flags[7:4], ~slot_num[0], flags[2:0]};
  assign rx_int    = (|(flags & en)) && !collide_q;

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_v & clr_v)) |=> (($past(set_v) & ~flags) == 8'h00));

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags & ~clr_v) & ~flags) == 8'h00));

  // R5
  last_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[4]) |-> flags[5]);

  // R9
  int_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> !rx_int);

  // R10
  dma_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_data |=> dma_req);

  // R10
  dma_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_data |=> !dma_req);

  // R7
  first_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd && slot_start && rx_count == '0) |=> flags[7]);
endmodule

// File: tb/rx_status_reg_tb.sv
`timescale 1ns/100ps
module rx_status_reg_tb;
  localparam int SW = 5;
  localparam int RW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic evt_data = 0, evt_last_slot = 0, evt_frame = 0;
  logic evt_clk_fail = 0, evt_sync_err = 0, evt_overrun = 0;
  logic [SW-1:0] slot_num = 1;
  logic slot_start = 0, port_rd = 0;
  logic [RW-1:0] rx_count = 2;
  logic reg_wr = 0, reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic rx_int, dma_req;

  rx_status_reg #(.SLOT_W(SW), .RD_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_data(evt_data), .evt_last_slot(evt_last_slot),
    .evt_frame(evt_frame), .evt_clk_fail(evt_clk_fail), .evt_sync_err(evt_sync_err),
    .evt_overrun(evt_overrun), .slot_num(slot_num), .slot_start(slot_start),
    .port_rd(port_rd), .rx_count(rx_count), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_int(rx_int), .dma_req(dma_req));

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  event  push_ev;
  int    checks = 0, errors = 0;
  bit    done = 0;

  logic [7:0] mflags = 0, men = 0;
  logic       mcq = 0, mdma = 0;
  int         mcnt = 0;

  initial forever begin
    @(push_ev);
    while (sbq.size() != 0) begin
      item_t it;
      logic [31:0] act;
      it  = sbq.pop_front();
      act = (it.kind == 0) ? reg_rdata : (it.kind == 1) ? {31'h0, rx_int} : {31'h0, dma_req};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [31:0] stat_exp();
    return {23'h0, mflags[0] | mflags[1] | mflags[2] | mflags[7], mflags[7:4],
            ~slot_num[0], mflags[2:0]};
  endfunction

  function automatic logic int_exp();
    return (|(mflags & men)) && !mcq;
  endfunction

  task automatic push(input int kind, input logic a, input logic [31:0] e, input string tag);
    item_t it;
    #0.1 reg_addr = a;
    #0.1;
    it.kind = kind; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    ->push_ev;
    #0.1;
  endtask

  task automatic chk_stat(input string tag);  push(0, 1'b0, stat_exp(), tag); endtask
  task automatic chk_int(input string tag);   push(1, 1'b0, {31'h0, int_exp()}, tag); endtask
  task automatic chk_dma(input string tag);   push(2, 1'b0, {31'h0, mdma}, tag); endtask

  // ev: [5] data, [4] last, [3] frame, [2] clock fail, [1] sync, [0] overrun
  task automatic act(input logic [5:0] ev, input logic rd, input logic ss,
                     input logic wr, input logic a, input logic [31:0] wd);
    logic [7:0] setm, clrm;
    int eff;
    logic over;
    eff  = ss ? 0 : mcnt;
    over = rd && (eff >= int'(rx_count));
    setm = {over, ev[3], ev[5], ev[5] & ev[4], 1'b0, ev[2], ev[1], ev[0]};
    clrm = (wr && !a) ? (wd[7:0] & 8'hF7) : 8'h00;
    #0.1;
    {evt_data, evt_last_slot, evt_frame, evt_clk_fail, evt_sync_err, evt_overrun} = ev;
    port_rd = rd; slot_start = ss; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    {evt_data, evt_last_slot, evt_frame, evt_clk_fail, evt_sync_err, evt_overrun} = 6'h0;
    port_rd = 0; slot_start = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    mcq    = |(setm & clrm & men);
    mflags = (mflags & ~clrm) | setm;
    if (wr && a) men = wd[7:0] & 8'hF7;
    mdma = ev[5];
    mcnt = eff + (rd ? 1 : 0);
  endtask

  task automatic idle();             act(6'h0, 0, 0, 0, 0, 32'h0); endtask
  task automatic clr_all();          act(6'h0, 0, 0, 1, 0, 32'hFFFF_FFFF); endtask
  task automatic fire(input logic [5:0] ev); act(ev, 0, 0, 0, 0, 32'h0); endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk_stat("R11 status after reset");
    push(0, 1'b1, 32'h0, "R11 enables after reset");
    chk_int("R11 rx_int after reset");
    chk_dma("R11 dma_req after reset");

    // R1 each event sets its flag
    for (int i = 0; i < 6; i++) begin
      if (i != 4) begin
        fire(6'(1 << i));
        chk_stat("R1 event sets flag");
      end
    end
    chk_stat("R4 aggregated error with several flags");

    // R5 last-slot qualifier alone
    clr_all();
    fire(6'b010000);
    chk_stat("R5 last alone has no effect");
    fire(6'b110000);
    chk_stat("R5 last with data");
    chk_dma("R10 dma_req after data");
    idle();
    chk_dma("R10 dma_req single cycle");

    // R2 write semantics, R11 reserved writes
    fire(6'b000111);
    act(6'h0, 0, 0, 1, 0, 32'h0);
    chk_stat("R2 write zero keeps flags");
    act(6'h0, 0, 0, 1, 0, 32'h0000_0001);
    chk_stat("R2 write one clears bit 0 only");
    act(6'h0, 0, 0, 1, 0, 32'hFFFF_FE00);
    chk_stat("R11 reserved write ignored");
    clr_all();
    chk_stat("R2 clear all");

    // R4 error aggregation per source
    fire(6'b000010); chk_stat("R4 sync error sets bit 8"); clr_all();
    fire(6'b000100); chk_stat("R4 clock fail sets bit 8"); clr_all();
    fire(6'b100000); chk_stat("R4 data does not set bit 8"); clr_all();

    // R8 enables
    act(6'h0, 0, 0, 1, 1, 32'hFFFF_FFFF);
    push(0, 1'b1, 32'h0000_00F7, "R8 enable readback mask");
    chk_int("R8 rx_int idle with no flags");
    fire(6'b000001);
    chk_int("R8 rx_int with enabled flag");
    clr_all();
    act(6'h0, 0, 0, 1, 1, 32'h0000_0001);
    fire(6'b000010);
    chk_int("R8 rx_int low for disabled flag");
    chk_dma("R10 no dma without data");
    clr_all();
    act(6'h0, 0, 0, 1, 1, 32'hFFFF_FFFF);

    // R3 / R9 collisions on each flag
    for (int i = 0; i < 6; i++) begin
      logic [5:0] ev;
      logic [7:0] bits;
      ev   = (i == 4) ? 6'b110000 : 6'(1 << i);
      bits = (i == 0) ? 8'h01 : (i == 1) ? 8'h02 : (i == 2) ? 8'h04 :
             (i == 3) ? 8'h40 : (i == 4) ? 8'h30 : 8'h20;
      fire(ev);
      act(ev, 0, 0, 1, 0, {24'h0, bits});
      chk_stat("R3 set wins over clear");
      chk_int("R9 rx_int gap after collision");
      if (i == 5) chk_dma("R10 dma_req during collision");
      idle();
      chk_int("R9 rx_int returns");
      clr_all();
      chk_stat("R2 flag cleared after collision");
    end

    // R7 read counter
    rx_count = 2;
    act(6'h0, 1, 1, 0, 0, 32'h0);
    act(6'h0, 1, 0, 0, 0, 32'h0);
    chk_stat("R7 reads at limit no error");
    act(6'h0, 1, 0, 0, 0, 32'h0);
    chk_stat("R7 read beyond limit flags");
    act(6'h0, 1, 0, 1, 0, 32'h80);
    chk_stat("R3 excess read set wins over clear");
    chk_int("R9 rx_int gap on excess read collision");
    clr_all();
    act(6'h0, 1, 1, 0, 0, 32'h0);
    act(6'h0, 1, 0, 0, 0, 32'h0);
    chk_stat("R7 counter cleared at slot boundary");
    rx_count = 0;
    act(6'h0, 1, 1, 0, 0, 32'h0);
    chk_stat("R7 zero receivers any read flags");
    clr_all();

    // R6 slot parity
    #0.1 slot_num = 2;
    chk_stat("R6 even slot");
    #0.1 slot_num = 3;
    chk_stat("R6 odd slot");

    done = 1;
    #0.1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule